// File: doc/BRIEF.md
# Threshold Programming Sequence Detector

This block sits behind a two-wire bus receiver and watches the decoded bus events (start strobes, stop strobes and received bytes) for the single write transaction that asks for a supply trip threshold to be reprogrammed. That transaction consists of a start, the device byte A0h, an address high byte of 00h, an address low byte that picks the threshold (01h for the main supply threshold, 0Dh for the second monitor threshold), one data byte of 00h, and then a stop.

Programming is allowed only when the write-enable latch is set at the time of the stop and the high programming voltage has been present on the protect pin from the start until the stop. When all conditions hold, the block raises a one-cycle programming pulse together with a select output that names the threshold. It then stays busy, ignoring all bus traffic, until the programming-voltage flag drops, which marks the end of the operation. Any deviation from the exact sequence returns the detector to idle without a pulse.

The bus receiver is assumed to raise at most one of the three strobes in a cycle. If more than one is raised anyway, stop is handled first, then start, then the byte.

Top module: `trip_prog_seq`

## Requirements
- R1: While rst_n is low at a clock edge, prog_pulse, prog_sel and busy are 0 after that edge, and the detector is idle.
- R2: The sequence start, byte A0h, byte 00h, byte 01h, byte 00h, stop, with wr_en_latch=1 at the stop and hv_present=1 throughout, gives prog_pulse=1 in the cycle after the stop is sampled, with prog_sel=0 (main threshold).
- R3: The same sequence with 0Dh as the address low byte gives the pulse with prog_sel=1 (second monitor threshold).
- R4: A device byte other than A0h, an address high byte other than 00h, an address low byte other than 01h or 0Dh, or a data byte other than 00h returns the detector to idle, and no pulse follows the stop.
- R5: A further byte received after the data byte and before the stop cancels the sequence, and no pulse follows.
- R6: A start received while a sequence is in progress returns the detector to idle. Bytes that follow it without a new start do not complete a sequence. A later fresh sequence is accepted.
- R7: If wr_en_latch is 0 when the stop is sampled, no pulse is issued, whichever threshold is selected.
- R8: If hv_present is 0 in any cycle between the start and the stop, the sequence is cancelled, and no pulse follows even if hv_present returns to 1.
- R9: prog_pulse is high for exactly one cycle. prog_sel changes only together with a pulse and otherwise holds its value.
- R10: busy becomes 1 in the same cycle as prog_pulse, stays 1 while hv_present is 1, and is 0 in the cycle after hv_present is sampled 0.
- R11: While busy is 1, a complete valid sequence gives no pulse.
- R12: Bytes and a stop that arrive without a preceding start give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_evt | input | 1 | One-cycle strobe: a start condition was decoded |
| stop_evt | input | 1 | One-cycle strobe: a stop condition was decoded |
| byte_vld | input | 1 | One-cycle strobe: byte_in holds a received byte |
| byte_in | input | 8 | Received byte |
| wr_en_latch | input | 1 | Write-enable latch state |
| hv_present | input | 1 | Programming voltage detected on the protect pin |
| prog_pulse | output | 1 | One-cycle request to program a threshold |
| prog_sel | output | 1 | Threshold selected: 0 main, 1 second monitor |
| busy | output | 1 | Programming in progress; bus traffic is ignored |

## Verification
Each strobe is held for one cycle, and one idle cycle follows it. The detector state is one register deep, and prog_pulse, prog_sel and busy are set at the clock edge that samples the stop, so the pulse is due one cycle after the stop. The bench samples it at the falling edge right after that rising edge, and checks that it is low again one cycle later. The busy flag clears at the edge that samples hv_present low, so the bench drops hv_present at a falling edge and reads busy at the next falling edge. Cancelled sequences are judged at the same point after the stop, where a pulse would have been due.

// File: rtl/trip_prog_pkg.sv
// Package: shared state encoding for the threshold programming detector.
// Assumes nothing beyond being compiled before the modules that import it.
package trip_prog_pkg;

    // Progress through the programming write transaction.
    typedef enum logic [2:0] {
        SQ_IDLE      = 3'd0,
        SQ_WAIT_DEV  = 3'd1,
        SQ_WAIT_AHI  = 3'd2,
        SQ_WAIT_ALO  = 3'd3,
        SQ_WAIT_DATA = 3'd4,
        SQ_WAIT_STOP = 3'd5
    } seq_state_t;

endpackage

// File: rtl/tps_seq_fsm.sv
// Module: tps_seq_fsm
// Follows decoded bus events through the exact programming write sequence.
// It reports when the last data byte has been accepted (armed) and which
// threshold the address low byte selected.
// Assumes: at most one strobe per cycle. If several come together, the
// priority is stop, then start, then byte. Hold or a missing programming
// voltage forces the state to idle.
module tps_seq_fsm
    import trip_prog_pkg::*;
#(
    parameter int          DW        = 8,
    parameter logic [DW-1:0] DEV_ID    = 8'hA0,
    parameter logic [DW-1:0] ADDR_HI   = 8'h00,
    parameter logic [DW-1:0] ADDR_MAIN = 8'h01,
    parameter logic [DW-1:0] ADDR_AUX  = 8'h0D,
    parameter logic [DW-1:0] DATA_VAL  = 8'h00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_evt,
    input  logic          stop_evt,
    input  logic          byte_vld,
    input  logic [DW-1:0] byte_in,
    input  logic          hv_present,
    input  logic          hold,
    output logic          armed,
    output logic          sel_q
);

    seq_state_t state_q, state_d;
    logic       sel_d;

    // Next-state selection for the sequence walk.
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        if (hold || !hv_present) begin
            state_d = SQ_IDLE;
        end else if (stop_evt) begin
            state_d = SQ_IDLE;
        end else if (start_evt) begin
            state_d = (state_q == SQ_IDLE) ? SQ_WAIT_DEV : SQ_IDLE;
        end else if (byte_vld) begin
            unique case (state_q)
                SQ_IDLE:      state_d = SQ_IDLE;
                SQ_WAIT_DEV:  state_d = (byte_in == DEV_ID)  ? SQ_WAIT_AHI  : SQ_IDLE;
                SQ_WAIT_AHI:  state_d = (byte_in == ADDR_HI) ? SQ_WAIT_ALO  : SQ_IDLE;
                SQ_WAIT_ALO: begin
                    if (byte_in == ADDR_MAIN) begin
                        state_d = SQ_WAIT_DATA;
                        sel_d   = 1'b0;
                    end else if (byte_in == ADDR_AUX) begin
                        state_d = SQ_WAIT_DATA;
                        sel_d   = 1'b1;
                    end else begin
                        state_d = SQ_IDLE;
                    end
                end
                SQ_WAIT_DATA: state_d = (byte_in == DATA_VAL) ? SQ_WAIT_STOP : SQ_IDLE;
                SQ_WAIT_STOP: state_d = SQ_IDLE;
                default:      state_d = SQ_IDLE;
            endcase
        end
    end

    // State and selection registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    assign armed = (state_q == SQ_WAIT_STOP);

    // R8: a missing programming voltage always leaves the walk idle.
    a_r8_hv_drop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_present |=> (state_q == SQ_IDLE));

    // R6: a start in mid-sequence aborts.
    a_r6_restart_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SQ_IDLE && start_evt && !stop_evt) |=> (state_q == SQ_IDLE));

    // R11: while held, no sequence progresses.
    a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (state_q == SQ_IDLE));

    // R5: armed lasts until the next event and never survives a further byte.
    a_r5_extra_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && byte_vld) |=> !armed);

endmodule

// File: rtl/tps_fire_ctl.sv
// Module: tps_fire_ctl
// Turns an armed sequence and its closing stop into a one-cycle
// programming pulse, latches the threshold selection, and keeps a busy
// flag until the programming voltage goes away.
// Assumes: armed and sel come from tps_seq_fsm in the same clock domain.
module tps_fire_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic sel_in,
    input  logic stop_evt,
    input  logic wr_en_latch,
    input  logic hv_present,
    output logic prog_pulse,
    output logic prog_sel,
    output logic busy
);

    logic fire;

    // Launch condition: closing stop with all qualifiers present.
    assign fire = armed && stop_evt && wr_en_latch && hv_present && !busy;

    // Pulse, selection and busy registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_pulse <= 1'b0;
            prog_sel   <= 1'b0;
            busy       <= 1'b0;
        end else begin
            prog_pulse <= fire;
            if (fire) begin
                prog_sel <= sel_in;
            end
            if (fire) begin
                busy <= 1'b1;
            end else if (!hv_present) begin
                busy <= 1'b0;
            end
        end
    end

    // R9: the pulse is one cycle wide.
    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        prog_pulse |=> !prog_pulse);

    // R9: the selection only moves with a pulse.
    a_r9_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_pulse |-> $stable(prog_sel));

    // R7: a pulse needs the write-enable latch at the stop.
    a_r7_wel_needed: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_latch) |=> !prog_pulse);

    // R10: busy holds while the voltage stays and clears once it goes.
    a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hv_present) |=> busy);
    a_r10_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_present |=> !busy);

    // R11: no new pulse while busy.
    a_r11_no_pulse_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !prog_pulse);

endmodule

// File: rtl/trip_prog_seq.sv
// Module: trip_prog_seq (top)
// Detects the threshold programming write on decoded two-wire bus events
// and issues a qualified programming pulse with a threshold select.
// Assumes: the event strobes are one cycle wide and synchronous to clk.
module trip_prog_seq #(
    parameter int            DW        = 8,
    parameter logic [DW-1:0] DEV_ID    = 8'hA0,
    parameter logic [DW-1:0] ADDR_HI   = 8'h00,
    parameter logic [DW-1:0] ADDR_MAIN = 8'h01,
    parameter logic [DW-1:0] ADDR_AUX  = 8'h0D,
    parameter logic [DW-1:0] DATA_VAL  = 8'h00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_evt,
    input  logic          stop_evt,
    input  logic          byte_vld,
    input  logic [DW-1:0] byte_in,
    input  logic          wr_en_latch,
    input  logic          hv_present,
    output logic          prog_pulse,
    output logic          prog_sel,
    output logic          busy
);

    logic armed;
    logic sel_w;

    // Sequence walker.
    tps_seq_fsm #(
        .DW(DW), .DEV_ID(DEV_ID), .ADDR_HI(ADDR_HI),
        .ADDR_MAIN(ADDR_MAIN), .ADDR_AUX(ADDR_AUX), .DATA_VAL(DATA_VAL)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .byte_vld(byte_vld), .byte_in(byte_in),
        .hv_present(hv_present), .hold(busy),
        .armed(armed), .sel_q(sel_w)
    );

    // Pulse and busy control.
    tps_fire_ctl u_fire (
        .clk(clk), .rst_n(rst_n),
        .armed(armed), .sel_in(sel_w),
        .stop_evt(stop_evt), .wr_en_latch(wr_en_latch),
        .hv_present(hv_present),
        .prog_pulse(prog_pulse), .prog_sel(prog_sel), .busy(busy)
    );

    // R2: a pulse is always the answer to a stop in the previous cycle.
    a_r2_pulse_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        prog_pulse |-> $past(stop_evt));

    // R10: busy only rises together with a pulse.
    a_r10_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> prog_pulse);

endmodule

// File: tb/tb_trip_prog_seq.sv
module tb_trip_prog_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_evt = 1'b0;
    logic       stop_evt = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       wr_en_latch = 1'b0;
    logic       hv_present = 1'b0;
    logic       prog_pulse, prog_sel, busy;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    trip_prog_seq dut (
        .clk(clk), .rst_n(rst_n),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .byte_vld(byte_vld), .byte_in(byte_in),
        .wr_en_latch(wr_en_latch), .hv_present(hv_present),
        .prog_pulse(prog_pulse), .prog_sel(prog_sel), .busy(busy)
    );

    // Row: dev, addr hi, addr lo, data, wel, expected pulse, expected sel, req
    typedef struct packed {
        logic [7:0] dev;
        logic [7:0] ahi;
        logic [7:0] alo;
        logic [7:0] dat;
        logic       wel;
        logic       exp_p;
        logic       exp_s;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'hA0, 8'h00, 8'h01, 8'h00, 1'b1, 1'b1, 1'b0, 4'd2},  // R2 main
        '{8'hA0, 8'h00, 8'h0D, 8'h00, 1'b1, 1'b1, 1'b1, 4'd3},  // R3 second
        '{8'hA1, 8'h00, 8'h01, 8'h00, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 device
        '{8'hA0, 8'h01, 8'h01, 8'h00, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 addr hi
        '{8'hA0, 8'h00, 8'h02, 8'h00, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 addr lo
        '{8'hA0, 8'h00, 8'h01, 8'hFF, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 data
        '{8'hA0, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 main
        '{8'hA0, 8'h00, 8'h0D, 8'h00, 1'b0, 1'b0, 1'b0, 4'd7}   // R7 second
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); start_evt = 1'b1;
        @(negedge clk); start_evt = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] b);
        @(negedge clk); byte_in = b; byte_vld = 1'b1;
        @(negedge clk); byte_vld = 1'b0;
    endtask

    // Returns at the falling edge just after the stop was sampled.
    task automatic do_stop();
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
    endtask

    task automatic seq4(input logic [7:0] a, b, c, d);
        do_start(); do_byte(a); do_byte(b); do_byte(c); do_byte(d);
    endtask

    task automatic clear_busy();
        @(negedge clk); hv_present = 1'b0;
        @(negedge clk); hv_present = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 pulse", prog_pulse, 0);
        chk("R1 sel", prog_sel, 0);
        chk("R1 busy", busy, 0);
        @(negedge clk); rst_n = 1'b1; hv_present = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            wr_en_latch = VECS[i].wel;
            seq4(VECS[i].dev, VECS[i].ahi, VECS[i].alo, VECS[i].dat);
            do_stop();
            chk($sformatf("R%0d row%0d pulse", VECS[i].req, i), prog_pulse, VECS[i].exp_p);
            if (VECS[i].exp_p) begin
                chk($sformatf("R%0d row%0d sel", VECS[i].req, i), prog_sel, VECS[i].exp_s);
                clear_busy();
            end
        end
        wr_en_latch = 1'b1;

        // R5: extra byte after data
        seq4(8'hA0, 8'h00, 8'h01, 8'h00); do_byte(8'h00); do_stop();
        chk("R5 extra byte", prog_pulse, 0);

        // R6: repeated start aborts, later bytes alone do not finish
        do_start(); do_byte(8'hA0); do_start();
        do_byte(8'h00); do_byte(8'h01); do_byte(8'h00); do_stop();
        chk("R6 restart", prog_pulse, 0);
        // R6: fresh sequence after abort accepted (second threshold)
        seq4(8'hA0, 8'h00, 8'h0D, 8'h00); do_stop();
        chk("R6 recovery pulse", prog_pulse, 1);
        chk("R6 recovery sel", prog_sel, 1);

        // R9: one cycle wide, sel held
        @(negedge clk);
        chk("R9 pulse width", prog_pulse, 0);
        chk("R9 sel held", prog_sel, 1);

        // R10: busy holds while voltage present
        repeat (3) @(negedge clk);
        chk("R10 busy held", busy, 1);

        // R11: valid sequence ignored while busy
        seq4(8'hA0, 8'h00, 8'h01, 8'h00); do_stop();
        chk("R11 no pulse busy", prog_pulse, 0);
        chk("R11 sel unchanged", prog_sel, 1);

        // R10: busy clears one cycle after voltage sampled low
        @(negedge clk); hv_present = 1'b0;
        @(negedge clk);
        chk("R10 busy clear", busy, 0);
        hv_present = 1'b1;

        // R8: voltage drop mid-sequence cancels
        do_start(); do_byte(8'hA0); do_byte(8'h00);
        @(negedge clk); hv_present = 1'b0;
        @(negedge clk); hv_present = 1'b1;
        do_byte(8'h01); do_byte(8'h00); do_stop();
        chk("R8 hv drop", prog_pulse, 0);
        chk("R8 busy", busy, 0);

        // R12: no start, no pulse
        do_byte(8'hA0); do_byte(8'h00); do_byte(8'h01); do_byte(8'h00); do_stop();
        chk("R12 no start", prog_pulse, 0);

        // R2: main threshold after everything else, sel back to 0
        seq4(8'hA0, 8'h00, 8'h01, 8'h00); do_stop();
        chk("R2 final pulse", prog_pulse, 1);
        chk("R2 final sel", prog_sel, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule